// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor whose registers are grouped into overlapping windows. The datapath always addresses 32 registers through a 5-bit number, and the block translates each number into a location of a larger physical store. Eight of the 32 registers are global: the same storage is seen from every window. The other 24 belong to the current window. They form three groups of eight: outgoing arguments (outs), private scratch values (locals) and incoming arguments (ins). The ins of a window are the same storage as the outs of the window that called it, so a caller passes arguments to a callee without copying them.

Two read ports are combinational and one write port is synchronous. A `save_req` strobe, issued on function entry, moves the current-window pointer to a fresh window. A `restore_req` strobe, issued on return, moves it back. One window is reserved as the boundary between the newest and the oldest window in use. A move onto the reserved window is refused, and the block raises an overflow or underflow flag for one cycle. The trap handler, outside this block, spills windows to memory and fills them back. The number of windows is the parameter `NWIN`. The pointer value after reset is the parameter `RST_CWP`.

A small state machine produces the trap flags. It has three states:
- `ST_RUN`: no trap.
- `ST_OVF`: a save was refused in the previous cycle.
- `ST_UNF`: a restore was refused in the previous cycle.

Every state uses the same transitions. A refused save goes to `ST_OVF` (transition *save_blocked*). A refused restore goes to `ST_UNF` (transition *restore_blocked*). Any other cycle goes to `ST_RUN` (transition *resume*).

Top module: `winreg_file`

## Requirements
- R1: Register numbers are decoded in four groups: 0–7 globals, 8–15 outs, 16–23 locals, 24–31 ins. A value written to a register number reads back from that number on both read ports while the window does not change.
- R2: Register 0 always reads as zero on both ports. A write to register 0 is discarded, and it is not bypassed.
- R3: Globals 1–7 read the same value in every window, before and after any save or restore.
- R4: After a successful save, the ins (24–31) return what the outs (8–15) held before the save, register for register (out k becomes in k). The locals show the new window's own storage, not the caller's locals.
- R5: After a successful restore, the outs return what the ins held before the restore. The locals and ins return the caller's values unchanged.
- R6: The following hold for the window pointer `cwp`:
  - Reset sets `cwp` to `RST_CWP`, sets every register to zero and clears both trap flags.
  - A successful save decrements `cwp` modulo `NWIN`.
  - A successful restore increments `cwp` modulo `NWIN`.
  - The new `cwp` is visible after the clock edge that samples the strobe.
  - With no strobe, `cwp` holds its value.
- R7: The reserved window is (`RST_CWP`+1) mod `NWIN`. A save whose target window is the reserved one leaves `cwp` unchanged and sets `ovf_trap` high for the following cycle.
- R8: A restore whose target window is the reserved one leaves `cwp` unchanged and sets `unf_trap` high for the following cycle.
- R9: When `save_req` and `restore_req` are both high in the same cycle, the save is performed and the restore is ignored.
- R10: When a write and a read in the same cycle resolve to the same physical register, the read port returns the write data in that cycle.
- R11: Each trap flag is high only in the cycle after a refused strobe, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Move to a new window (function entry) |
| restore_req | input | 1 | Return to the previous window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | XLEN | Write data |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | XLEN | Read data for port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | XLEN | Read data for port B |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | One-cycle pulse: a save was refused |
| unf_trap | output | 1 | One-cycle pulse: a restore was refused |

## Verification
A wrong window pointer shows on `cwp` one edge after the strobe. It also shows through the reads: an in or local register read in the same cycle returns another window's data. A mistake in the overlap between adjacent windows stays hidden until a value written as an out is read as an in after a save, or the reverse after a restore. A wrong reserved-window decision shows one cycle later, as a missing or extra trap pulse together with a pointer that moved when it should not. A bypass fault shows only on a same-cycle write and read of the same physical register, in the cycle of the write itself.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    // Trap-flag state machine states.
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_OVF = 2'd1,
        ST_UNF = 2'd2
    } trap_state_t;

    // Register-number group codes (bits 4:3 of the register number).
    localparam logic [1:0] GRP_GLOBAL = 2'b00;
    localparam logic [1:0] GRP_OUTS   = 2'b01;
    localparam logic [1:0] GRP_LOCALS = 2'b10;
    localparam logic [1:0] GRP_INS    = 2'b11;

    localparam int REG_AW = 5;

endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int PW = CW + 4
) (
    input  logic [CW-1:0]                   cwp,
    input  logic [winreg_pkg::REG_AW-1:0]   addr,
    output logic                            is_glob,
    output logic [2:0]                      gidx,
    output logic [PW-1:0]                   phys
);
    import winreg_pkg::*;

    logic [CW-1:0] win_sel;
    logic [3:0]    slot;

    // Ins live in the outs slots of the next-higher window (the caller).
    always_comb begin
        is_glob = (addr[4:3] == GRP_GLOBAL);
        gidx    = addr[2:0];
        if (addr[4:3] == GRP_INS)
            win_sel = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;
        else
            win_sel = cwp;
        slot = {addr[4:3] == GRP_LOCALS, addr[2:0]};
        phys = {win_sel, slot};
    end

endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int XLEN = 32,
    parameter int NWIN = 8,
    parameter int NRD  = 2,
    localparam int CW    = $clog2(NWIN),
    localparam int PW    = CW + 4,
    localparam int NPHYS = 16 * NWIN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_glob,
    input  logic [2:0]                wr_gidx,
    input  logic [PW-1:0]             wr_phys,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [NRD-1:0]            rd_glob,
    input  logic [NRD-1:0][2:0]       rd_gidx,
    input  logic [NRD-1:0][PW-1:0]    rd_phys,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);
    logic [XLEN-1:0] glob_q [8];
    logic [XLEN-1:0] win_q  [NPHYS];
    logic            wr_live;

    // Writes to register 0 never land and never bypass.
    assign wr_live = wr_en && !(wr_glob && (wr_gidx == 3'd0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 8; g++) glob_q[g] <= '0;
            for (int w = 0; w < NPHYS; w++) win_q[w] <= '0;
        end else if (wr_live) begin
            if (wr_glob) glob_q[wr_gidx] <= wr_data;
            else         win_q[wr_phys]  <= wr_data;
        end
    end

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            logic hit;
            always_comb begin
                hit = wr_live && (wr_glob == rd_glob[p]) &&
                      (rd_glob[p] ? (wr_gidx == rd_gidx[p]) : (wr_phys == rd_phys[p]));
                if (rd_glob[p] && rd_gidx[p] == 3'd0)
                    rd_data[p] = '0;
                else if (hit)
                    rd_data[p] = wr_data;
                else if (rd_glob[p])
                    rd_data[p] = glob_q[rd_gidx[p]];
                else
                    rd_data[p] = win_q[rd_phys[p]];
            end
        end
    endgenerate

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
    parameter int NWIN    = 8,
    parameter int RST_CWP = 0,
    localparam int CW = $clog2(NWIN),
    localparam int RSV = (RST_CWP + 1) % NWIN,
    localparam logic [NWIN-1:0] INV_MASK = NWIN'(1) << RSV
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [CW-1:0] cwp,
    output logic          ovf_trap,
    output logic          unf_trap
);
    import winreg_pkg::*;

    trap_state_t   state_q, state_d;
    logic [CW-1:0] cwp_q, cwp_d, cwp_dn, cwp_up;
    logic          save_blk, rest_blk, rest_act;

    always_comb begin
        cwp_dn   = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
        cwp_up   = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
        rest_act = restore_req && !save_req;
        save_blk = save_req && INV_MASK[cwp_dn];
        rest_blk = rest_act && INV_MASK[cwp_up];
        if (save_req && !save_blk)      cwp_d = cwp_dn;
        else if (rest_act && !rest_blk) cwp_d = cwp_up;
        else                            cwp_d = cwp_q;
    end

    // Next state: every state shares the same transitions.
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_OVF, ST_UNF: begin
                if (save_blk)      state_d = ST_OVF;
                else if (rest_blk) state_d = ST_UNF;
                else               state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cwp_q   <= CW'(RST_CWP);
        end else begin
            state_q <= state_d;
            cwp_q   <= cwp_d;
        end
    end

    // Outputs.
    always_comb begin
        ovf_trap = (state_q == ST_OVF);
        unf_trap = (state_q == ST_UNF);
        cwp      = cwp_q;
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int NWIN    = 8,
    parameter int XLEN    = 32,
    parameter int RST_CWP = 0,
    localparam int CW = $clog2(NWIN),
    localparam int PW = CW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [4:0]      rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [4:0]      rd_addr_b,
    output logic [XLEN-1:0] rd_data_b,
    output logic [CW-1:0]   cwp,
    output logic            ovf_trap,
    output logic            unf_trap
);
    localparam int NADDR = 3;  // read A, read B, write

    logic [NADDR-1:0][4:0]    addr_v;
    logic [NADDR-1:0]         glob_v;
    logic [NADDR-1:0][2:0]    gidx_v;
    logic [NADDR-1:0][PW-1:0] phys_v;
    logic [1:0][XLEN-1:0]     rdat_v;

    assign addr_v = {wr_addr, rd_addr_b, rd_addr_a};

    winreg_ctrl #(.NWIN(NWIN), .RST_CWP(RST_CWP)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .cwp         (cwp),
        .ovf_trap    (ovf_trap),
        .unf_trap    (unf_trap)
    );

    generate
        for (genvar p = 0; p < NADDR; p++) begin : g_map
            winreg_map #(.NWIN(NWIN)) u_map (
                .cwp     (cwp),
                .addr    (addr_v[p]),
                .is_glob (glob_v[p]),
                .gidx    (gidx_v[p]),
                .phys    (phys_v[p])
            );
        end
    endgenerate

    winreg_store #(.XLEN(XLEN), .NWIN(NWIN), .NRD(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_glob (glob_v[2]),
        .wr_gidx (gidx_v[2]),
        .wr_phys (phys_v[2]),
        .wr_data (wr_data),
        .rd_glob (glob_v[1:0]),
        .rd_gidx (gidx_v[1:0]),
        .rd_phys (phys_v[1:0]),
        .rd_data (rdat_v)
    );

    assign rd_data_a = rdat_v[0];
    assign rd_data_b = rdat_v[1];

endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int CW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            save_req,
    input logic            restore_req,
    input logic [4:0]      rd_addr_a,
    input logic [XLEN-1:0] rd_data_a,
    input logic [4:0]      rd_addr_b,
    input logic [XLEN-1:0] rd_data_b,
    input logic [CW-1:0]   cwp,
    input logic            ovf_trap,
    input logic            unf_trap
);
    logic [CW-1:0] exp_dn, exp_up;
    assign exp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - 1'b1;
    assign exp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + 1'b1;

    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr_a == 5'd0) |-> (rd_data_a == '0)) and
        ((rd_addr_b == 5'd0) |-> (rd_data_b == '0)));

    assert_save_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        save_req |=> ((cwp == $past(exp_dn)) || ovf_trap));

    assert_restore_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req) |=> ((cwp == $past(exp_up)) || unf_trap));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_req && !restore_req) |=> ($stable(cwp) && !ovf_trap && !unf_trap));

    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap |-> ($past(save_req) && (cwp == $past(cwp))));

    assert_unf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap |-> ($past(restore_req) && !$past(save_req) && (cwp == $past(cwp))));

    assert_save_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> !unf_trap);

    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ovf_trap, unf_trap}) <= 1);

endmodule

bind winreg_file winreg_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rd_addr_a   (rd_addr_a),
    .rd_data_a   (rd_data_a),
    .rd_addr_b   (rd_addr_b),
    .rd_data_b   (rd_data_b),
    .cwp         (cwp),
    .ovf_trap    (ovf_trap),
    .unf_trap    (unf_trap)
);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
    localparam int NW   = 8;
    localparam int XL   = 32;
    localparam int RSV  = 1;          // (RST_CWP + 1) mod NW with RST_CWP = 0
    localparam int NREG = 8 + 16 * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          save_req = 1'b0, restore_req = 1'b0, wr_en = 1'b0;
    logic [4:0]    wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
    logic [XL-1:0] wr_data = '0;
    logic [XL-1:0] rd_data_a, rd_data_b;
    logic [2:0]    cwp;
    logic          ovf_trap, unf_trap;

    always #10 clk = ~clk;  // 50 MHz

    winreg_file #(.NWIN(NW), .XLEN(XL), .RST_CWP(0)) u0 (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    int            errs = 0, checks = 0;
    logic [XL-1:0] mm [NREG];
    int            mcwp = 0;

    task automatic chk(input bit ok, input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model index: 0..7 globals, 8.. windowed storage (16 per window).
    function automatic int midx(int a, int c);
        int w;
        if (a < 8) return a;
        w = (a >= 24) ? (c + 1) % NW : c;
        return 8 + w * 16 + ((a >= 16 && a < 24) ? 8 : 0) + (a % 8);
    endfunction

    function automatic logic [XL-1:0] eread(int a);
        if (a == 0) return '0;
        if (wr_en && wr_addr != 0 && midx(int'(wr_addr), mcwp) == midx(a, mcwp)) return wr_data;
        return mm[midx(a, mcwp)];
    endfunction

    task automatic cyc(input bit sv, input bit rs, input bit we, input logic [4:0] wa,
                       input logic [XL-1:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                       input string tag);
        bit eo, eu;
        int nc;
        logic [XL-1:0] ea, eb;
        @(negedge clk);
        save_req = sv; restore_req = rs; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        #5;
        ea = eread(int'(ra)); eb = eread(int'(rb));
        chk(rd_data_a === ea, {tag, " port A"}, rd_data_a, ea);
        chk(rd_data_b === eb, {tag, " port B"}, rd_data_b, eb);
        eo = sv && ((mcwp + NW - 1) % NW == RSV);
        eu = !sv && rs && ((mcwp + 1) % NW == RSV);
        nc = mcwp;
        if (sv && !eo) nc = (mcwp + NW - 1) % NW;
        else if (!sv && rs && !eu) nc = (mcwp + 1) % NW;
        @(posedge clk);
        #1;
        if (we && wa != 0) mm[midx(int'(wa), mcwp)] = wd;
        mcwp = nc;
        #2;
        chk(int'(cwp) == nc, "R6 window pointer", 32'(cwp), 32'(nc));
        chk(ovf_trap == eo, "R7 overflow flag", 32'(ovf_trap), 32'(eo));
        chk(unf_trap == eu, "R8 underflow flag", 32'(unf_trap), 32'(eu));
        chk(!(ovf_trap && unf_trap), "R11 flags exclusive", {ovf_trap, unf_trap}, 32'd0);
    endtask

    task automatic rd(input logic [4:0] ra, input logic [4:0] rb, input string tag);
        cyc(1'b0, 1'b0, 1'b0, 5'd0, '0, ra, rb, tag);
    endtask

    initial begin
        #(20 * 200000);
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int i = 0; i < NREG; i++) mm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_addr_a = 5'd13; rd_addr_b = 5'd29;
        #5;
        // R6 reset state
        chk(cwp == 3'd0, "R6 reset pointer", 32'(cwp), 32'd0);
        chk(!ovf_trap && !unf_trap, "R6 reset flags", {ovf_trap, unf_trap}, 32'd0);
        chk(rd_data_a == '0 && rd_data_b == '0, "R6 reset contents", rd_data_a | rd_data_b, 32'd0);

        // R2 register 0 write dropped, also not bypassed
        cyc(1'b0, 1'b0, 1'b1, 5'd0, 32'hdead_beef, 5'd0, 5'd0, "R2 zero bypass");
        rd(5'd0, 5'd0, "R2 zero read");

        // R1 one write per group
        cyc(1'b0, 1'b0, 1'b1, 5'd3,  32'h0000_0a03, 5'd3, 5'd0, "R1 global");
        cyc(1'b0, 1'b0, 1'b1, 5'd10, 32'h0000_0b0a, 5'd3, 5'd10, "R1 out");
        cyc(1'b0, 1'b0, 1'b1, 5'd17, 32'h0000_0c11, 5'd17, 5'd10, "R1 local");
        cyc(1'b0, 1'b0, 1'b1, 5'd28, 32'h0000_0d1c, 5'd28, 5'd17, "R1 in");
        // R10 same-cycle bypass
        cyc(1'b0, 1'b0, 1'b1, 5'd20, 32'h1357_9bdf, 5'd20, 5'd7, "R10 bypass");
        rd(5'd20, 5'd28, "R1 readback");

        // Restore from reset window: underflow (R8)
        cyc(1'b0, 1'b1, 1'b0, 5'd0, '0, 5'd10, 5'd28, "R8 restore at reset");
        chk(unf_trap && cwp == 3'd0, "R8 pointer kept with trap", 32'(cwp), 32'd0);

        // R4 save: out 10 becomes in 26; locals fresh
        cyc(1'b1, 1'b0, 1'b0, 5'd0, '0, 5'd10, 5'd17, "R4 before save");
        rd(5'd26, 5'd17, "R4 after save");
        rd(5'd3, 5'd3, "R3 global after save");
        cyc(1'b0, 1'b0, 1'b1, 5'd17, 32'h0000_face, 5'd17, 5'd26, "R4 callee local");
        cyc(1'b0, 1'b0, 1'b1, 5'd24, 32'h0000_0099, 5'd24, 5'd3, "R4 return value");
        // R5 restore: in 24 becomes out 8; caller local and in intact
        cyc(1'b0, 1'b1, 1'b0, 5'd0, '0, 5'd24, 5'd17, "R5 before restore");
        rd(5'd8, 5'd17, "R5 after restore");
        rd(5'd28, 5'd3, "R5 caller ins");

        // R7 fill windows: six saves succeed, the seventh traps
        for (int k = 0; k < 7; k++)
            cyc(1'b1, 1'b0, 1'b1, 5'(8 + k), 32'(k + 100), 5'd3, 5'(24 + k), "R7 save chain");
        chk(cwp == 3'd2 && ovf_trap, "R7 pointer at limit", 32'(cwp), 32'd2);

        // R9 simultaneous strobes: save wins
        cyc(1'b0, 1'b1, 1'b0, 5'd0, '0, 5'd24, 5'd8, "R9 setup");
        cyc(1'b1, 1'b1, 1'b0, 5'd0, '0, 5'd24, 5'd8, "R9 both");
        chk(cwp == 3'd2 && !unf_trap, "R9 save wins", 32'(cwp), 32'd2);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            cyc(op == 3'd0, op == 3'd1 || op == 3'd2, 1'($urandom_range(0, 1)),
                5'($urandom_range(0, 31)), $urandom(), 5'($urandom_range(0, 31)),
                5'($urandom_range(0, 31)), "R1 random");
        end

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule